// File: doc/BRIEF.md
# Bus-Configurable Serial Port With Run-Time Baud Derivation

This block is a byte-wide asynchronous serial port (8 data bits, no parity, one stop bit) placed behind a small strobe-and-acknowledge slave port. The slave port has a 2-bit register select and 32-bit data buses. Software configures the port by writing two plain integers: the frequency of the system clock in Hz and the wanted line rate in bits per second. The block then divides one by the other in hardware to get the number of clocks per serial bit. No precomputed divisor is written by software.

Once the divisor is valid, writing a byte to the transmit register sends one frame on the serial output. The receiver watches the serial input, confirms a start bit at half a bit time, and samples each bit at its centre. When a frame with a good stop bit completes, the receiver raises a ready flag and keeps the byte for a read of the receive register. Reading the receive register clears the flag.

Top module: `uart_bus_peripheral`

## Requirements
- R1: The register select picks one of four registers: code 0 is the clock frequency in Hz, code 1 is the line rate in bits per second, code 2 is the transmit byte (write only), and code 3 is the received byte (read only). Reads of codes 0 and 1 return the last written 32-bit value. Reads of code 2 return zero.
- R2: An access is taken when the strobe is high and acknowledge is low. Acknowledge is a single-cycle pulse in the clock cycle after the strobe is seen, and it is low in the following cycle even if the strobe is still held. The write enable chooses between write (1) and read (0).
- R3: Each write to code 0 or code 1 starts a sequential division of the frequency by the line rate, which finishes within 34 clocks. The result is valid only if the line rate is nonzero and the quotient is at least 2. While the result is invalid, the transmitter holds the line high and ignores transmit writes, and the receiver accepts no frames.
- R4: A transmit frame is one low start bit, then the 8 data bits with the least significant bit first, then one high stop bit. Each bit lasts exactly divisor clocks. The start bit appears on the line in the same edge that acknowledges the write, and the line idles high.
- R5: A write to code 2 while a frame is being sent is acknowledged but has no effect: the frame in flight is unchanged and no second frame follows.
- R6: After a received frame with a high stop bit, the ready output rises. A read of code 3 returns the byte in bits 7:0, with bits 31:8 zero.
- R7: A read of code 3 clears the ready output, unless a new frame completes in the same cycle.
- R8: A frame that completes before the held byte is read overwrites it. The ready flag stays high.
- R9: A frame whose stop bit is sampled low is discarded: the ready flag does not rise and the held byte is kept.
- R10: A low pulse on the serial input that has returned high at half a bit time is rejected as a false start and produces no byte.
- R11: Synchronous active-high reset leaves the serial output high, ready low, acknowledge low and the divisor invalid. A transmit write made right after reset, before any configuration, sends nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_adr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while acknowledge is high |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_stb | input | 1 | Access strobe, held until acknowledge |
| bus_ack | output | 1 | One-cycle access acknowledge |
| ser_rx | input | 1 | Serial receive line |
| rx_ready | output | 1 | A received byte is waiting |
| ser_tx | output | 1 | Serial transmit line |

## Verification
A wrong divisor shows up as stretched or shrunk bits on the serial output, and the bench measures this at bit centres within the first frame after configuration. A wrong receive state, such as a missed start confirmation or a bad stop-bit decision, shows up at the end of the frame: the ready flag fails to rise or rises when it should not, or the byte read back is wrong. Decode or handshake faults show up in the cycle after the strobe, as a missing or repeated acknowledge or as wrong read data. A transmit state that does not return to idle shows up as an extra frame or a line that does not go high, within one frame time.

// File: rtl/uart_periph_pkg.sv
package uart_periph_pkg;

    typedef enum logic [1:0] {
        REG_CLK_HZ = 2'b00,
        REG_BAUD   = 2'b01,
        REG_TXD    = 2'b10,
        REG_RXD    = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/baud_div_seq.sv
module baud_div_seq #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] numer,
    input  logic [W-1:0] denom,
    output logic [W-1:0] quot,
    output logic         valid
);
    localparam int unsigned CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  num;
        logic [W-1:0]  den;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  res;
        logic          valid;
    } div_regs_t;

    div_regs_t q, d;
    logic [W:0]   shifted;
    logic [W-1:0] quo_next;

    always_comb begin
        d        = q;
        shifted  = {q.rem[W-1:0], q.num[W-1]};
        quo_next = q.quo;
        if (start) begin
            d.busy  = 1'b1;
            d.cnt   = '0;
            d.num   = numer;
            d.den   = denom;
            d.rem   = '0;
            d.quo   = '0;
            d.valid = 1'b0;
        end else if (q.busy) begin
            d.num = {q.num[W-2:0], 1'b0};
            if (shifted >= {1'b0, q.den}) begin
                d.rem    = shifted - {1'b0, q.den};
                quo_next = {q.quo[W-2:0], 1'b1};
            end else begin
                d.rem    = shifted;
                quo_next = {q.quo[W-2:0], 1'b0};
            end
            d.quo = quo_next;
            d.cnt = q.cnt + CW'(1);
            if (q.cnt == CW'(W - 1)) begin
                d.busy  = 1'b0;
                d.res   = quo_next;
                d.valid = (q.den != '0) && (quo_next >= W'(2));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign quot  = q.res;
    assign valid = q.valid;

    // R3
    valid_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(q.valid) |-> $fell(q.busy));

    // R3
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        q.busy |-> (q.cnt < CW'(W)));

endmodule

// File: rtl/uart_tx_eng.sv
module uart_tx_eng #(
    parameter int unsigned W      = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [W-1:0]      bit_len,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              ser,
    output logic              busy
);
    localparam int unsigned FRAME = BYTE_W + 2;
    localparam int unsigned BCW   = $clog2(FRAME + 1);

    typedef struct packed {
        logic             busy;
        logic [FRAME-1:0] shreg;
        logic [BCW-1:0]   bitn;
        logic [W-1:0]     tick;
        logic             line;
    } tx_regs_t;

    tx_regs_t q, d;

    always_comb begin
        d = q;
        if (!enable) begin
            d.busy = 1'b0;
            d.line = 1'b1;
        end else if (!q.busy) begin
            d.line = 1'b1;
            if (load) begin
                d.busy  = 1'b1;
                d.shreg = {1'b1, load_byte, 1'b0};
                d.bitn  = '0;
                d.tick  = '0;
                d.line  = 1'b0;
            end
        end else begin
            if (q.tick == bit_len - W'(1)) begin
                d.tick = '0;
                if (q.bitn == BCW'(FRAME - 1)) begin
                    d.busy = 1'b0;
                    d.line = 1'b1;
                end else begin
                    d.bitn  = q.bitn + BCW'(1);
                    d.shreg = {1'b1, q.shreg[FRAME-1:1]};
                    d.line  = q.shreg[1];
                end
            end else begin
                d.tick = q.tick + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ser  = q.line;
    assign busy = q.busy;

    // R4
    stop_bit_high_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(q.busy) && enable) |-> $past(q.line));

    // R4
    bit_index_chk: assert property (@(posedge clk) disable iff (rst)
        q.busy |-> (q.bitn < BCW'(FRAME)));

endmodule

// File: rtl/uart_rx_eng.sv
module uart_rx_eng
    import uart_periph_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [W-1:0]      bit_len,
    input  logic              ser_in,
    output logic              got,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int unsigned BIW = $clog2(BYTE_W);

    typedef struct packed {
        logic              s1;
        logic              s2;
        rx_state_e         state;
        logic [W-1:0]      tick;
        logic [BIW-1:0]    bitn;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] hold;
        logic              got;
    } rx_regs_t;

    rx_regs_t q, d;
    logic [W-1:0] half_len;

    always_comb begin
        d        = q;
        half_len = bit_len >> 1;
        d.s1     = ser_in;
        d.s2     = q.s1;
        d.got    = 1'b0;
        if (!enable) begin
            d.state = RX_IDLE;
        end else begin
            unique case (q.state)
                RX_IDLE: begin
                    if (!q.s2) begin
                        d.state = RX_START;
                        d.tick  = '0;
                    end
                end
                RX_START: begin
                    if (q.tick == half_len - W'(1)) begin
                        d.tick = '0;
                        d.bitn = '0;
                        d.state = q.s2 ? RX_IDLE : RX_DATA;
                    end else begin
                        d.tick = q.tick + W'(1);
                    end
                end
                RX_DATA: begin
                    if (q.tick == bit_len - W'(1)) begin
                        d.tick  = '0;
                        d.shreg = {q.s2, q.shreg[BYTE_W-1:1]};
                        if (q.bitn == BIW'(BYTE_W - 1)) d.state = RX_STOP;
                        else                            d.bitn  = q.bitn + BIW'(1);
                    end else begin
                        d.tick = q.tick + W'(1);
                    end
                end
                RX_STOP: begin
                    if (q.tick == bit_len - W'(1)) begin
                        d.state = RX_IDLE;
                        d.tick  = '0;
                        if (q.s2) begin
                            d.got  = 1'b1;
                            d.hold = q.shreg;
                        end
                    end else begin
                        d.tick = q.tick + W'(1);
                    end
                end
                default: d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
            q.state <= RX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign got     = q.got;
    assign rx_byte = q.hold;

    // R9
    stop_sampled_high_chk: assert property (@(posedge clk) disable iff (rst)
        q.got |-> ($past(q.state) == RX_STOP) && $past(q.s2));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !q.got |-> $stable(q.hold));

endmodule

// File: rtl/uart_bus_peripheral.sv
module uart_bus_peripheral
    import uart_periph_pkg::*;
#(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_adr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             bus_we,
    input  logic             bus_stb,
    output logic             bus_ack,
    input  logic             ser_rx,
    output logic             rx_ready,
    output logic             ser_tx
);
    localparam int unsigned PAD_W = BUS_W - BYTE_W;

    typedef struct packed {
        logic             ack;
        logic [BUS_W-1:0] rdata;
        logic [BUS_W-1:0] clk_hz;
        logic [BUS_W-1:0] baud;
        logic             ready;
        logic             div_go;
    } bus_regs_t;

    bus_regs_t q, d;

    logic              acc, wr, rd;
    reg_sel_e          sel;
    logic              tx_load;
    logic [BUS_W-1:0]  div_val;
    logic              div_ok;
    logic              tx_busy;
    logic              rx_got;
    logic [BYTE_W-1:0] rx_byte;

    always_comb begin
        acc     = bus_stb && !q.ack;
        wr      = acc && bus_we;
        rd      = acc && !bus_we;
        sel     = reg_sel_e'(bus_adr);
        tx_load = wr && (sel == REG_TXD);
        d        = q;
        d.ack    = acc;
        d.div_go = 1'b0;
        if (wr) begin
            unique case (sel)
                REG_CLK_HZ: begin d.clk_hz = bus_wdata; d.div_go = 1'b1; end
                REG_BAUD:   begin d.baud   = bus_wdata; d.div_go = 1'b1; end
                default: ;
            endcase
        end
        if (rd) begin
            unique case (sel)
                REG_CLK_HZ: d.rdata = q.clk_hz;
                REG_BAUD:   d.rdata = q.baud;
                REG_TXD:    d.rdata = '0;
                REG_RXD:    d.rdata = {{PAD_W{1'b0}}, rx_byte};
                default:    d.rdata = '0;
            endcase
        end
        if (rx_got)                        d.ready = 1'b1;
        else if (rd && (sel == REG_RXD))   d.ready = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    baud_div_seq #(.W(BUS_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (q.div_go),
        .numer (q.clk_hz),
        .denom (q.baud),
        .quot  (div_val),
        .valid (div_ok)
    );

    uart_tx_eng #(.W(BUS_W), .BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .enable    (div_ok),
        .bit_len   (div_val),
        .load      (tx_load),
        .load_byte (bus_wdata[BYTE_W-1:0]),
        .ser       (ser_tx),
        .busy      (tx_busy)
    );

    uart_rx_eng #(.W(BUS_W), .BYTE_W(BYTE_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .enable  (div_ok),
        .bit_len (div_val),
        .ser_in  (ser_rx),
        .got     (rx_got),
        .rx_byte (rx_byte)
    );

    assign bus_ack   = q.ack;
    assign bus_rdata = q.rdata;
    assign rx_ready  = q.ready;

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    // R2
    ack_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> $past(bus_stb));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && (sel == REG_RXD) && !rx_got) |=> !rx_ready);

    // R6
    rx_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && $past(bus_stb && !bus_we && (bus_adr == 2'b11)))
            |-> (bus_rdata[BUS_W-1:BYTE_W] == '0));

    // R3
    tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !div_ok |=> ser_tx);

    // R5
    no_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && tx_load && div_ok) |=> (tx_busy || ser_tx));

endmodule

// File: tb/uart_bus_peripheral_tb.sv
`timescale 1ns/1ps
module uart_bus_peripheral_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_adr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_we = 1'b0;
    logic        bus_stb = 1'b0;
    logic        bus_ack;
    logic        ser_rx = 1'b1;
    logic        rx_ready;
    logic        ser_tx;

    int checks = 0;
    int errs   = 0;

    always #2.5 clk = ~clk;

    uart_bus_peripheral u_dut (
        .clk(clk), .rst(rst), .bus_adr(bus_adr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_we(bus_we), .bus_stb(bus_stb),
        .bus_ack(bus_ack), .ser_rx(ser_rx), .rx_ready(rx_ready), .ser_tx(ser_tx)
    );

    localparam int NV = 4;
    localparam logic [31:0] V_CLK  [NV] = '{32'd64, 32'd100, 32'd90, 32'd33};
    localparam logic [31:0] V_BAUD [NV] = '{32'd4,  32'd10,  32'd7,  32'd3};
    localparam logic [7:0]  V_TX   [NV] = '{8'hC4, 8'h55, 8'h01, 8'hFE};
    localparam logic [7:0]  V_RX   [NV] = '{8'h3A, 8'hAA, 8'h80, 8'h7F};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_access(input logic [1:0] a, input logic w,
                              input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_adr = a; bus_we = w; bus_wdata = wd; bus_stb = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_ack) break;
        end
        rd = bus_rdata;
        bus_stb = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] wd);
        logic [31:0] dummy;
        bus_access(a, 1'b1, wd, dummy);
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [31:0] rd);
        bus_access(a, 1'b0, 32'h0, rd);
    endtask

    task automatic configure(input logic [31:0] hz, input logic [31:0] bd);
        wr(2'b00, hz);
        wr(2'b01, bd);
        repeat (40) @(negedge clk);
    endtask

    // samples a frame at bit centres, starting from the start-bit edge
    task automatic capture(input int dv, output logic [9:0] fr);
        fr = '1;
        for (int i = 0; i < 2000; i++) begin
            if (!ser_tx) break;
            @(negedge clk);
        end
        repeat (dv / 2) @(negedge clk);
        for (int b = 0; b < 10; b++) begin
            fr[b] = ser_tx;
            if (b < 9) repeat (dv) @(negedge clk);
        end
        repeat (dv) @(negedge clk);
    endtask

    task automatic send(input int dv, input logic [7:0] by, input logic stop);
        logic [9:0] fr;
        fr = {stop, by, 1'b0};
        for (int b = 0; b < 10; b++) begin
            @(negedge clk);
            ser_rx = fr[b];
            repeat (dv - 1) @(negedge clk);
        end
        @(negedge clk);
        ser_rx = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic quiet_check(input int n, input string req, input string what);
        logic seen_low;
        seen_low = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!ser_tx) seen_low = 1'b1;
        end
        chk(!seen_low, req, what, seen_low, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [9:0]  fr;
        int          dv;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(ser_tx == 1'b1, "R11", "ser_tx after reset", ser_tx, 1);
        chk(rx_ready == 1'b0, "R11", "ready after reset", rx_ready, 0);
        chk(bus_ack == 1'b0, "R11", "ack after reset", bus_ack, 0);

        // R11 / R3: transmit write with no divisor sends nothing
        wr(2'b10, 32'h0000_00A5);
        quiet_check(200, "R11", "line quiet without divisor");

        // R2: strobe held across two cycles gives one pulse then low
        @(negedge clk);
        bus_adr = 2'b00; bus_we = 1'b0; bus_stb = 1'b1;
        @(negedge clk);
        chk(bus_ack == 1'b1, "R2", "ack one cycle after strobe", bus_ack, 1);
        @(negedge clk);
        chk(bus_ack == 1'b0, "R2", "ack low in next cycle", bus_ack, 0);
        bus_stb = 1'b0;
        repeat (2) @(negedge clk);

        // table walk: configure, transmit, receive, read back
        for (int v = 0; v < NV; v++) begin
            dv = int'(V_CLK[v] / V_BAUD[v]);
            configure(V_CLK[v], V_BAUD[v]);
            rdreg(2'b00, rv);
            chk(rv == V_CLK[v], "R1", "clock register readback", rv, V_CLK[v]);
            rdreg(2'b01, rv);
            chk(rv == V_BAUD[v], "R1", "rate register readback", rv, V_BAUD[v]);
            wr(2'b10, {24'h0, V_TX[v]});
            capture(dv, fr);
            chk(fr == {1'b1, V_TX[v], 1'b0}, "R4", "transmit frame", fr, {1'b1, V_TX[v], 1'b0});
            send(dv, V_RX[v], 1'b1);
            chk(rx_ready == 1'b1, "R6", "ready after frame", rx_ready, 1);
            rdreg(2'b11, rv);
            chk(rv == {24'h0, V_RX[v]}, "R6", "received byte", rv, {24'h0, V_RX[v]});
            @(negedge clk);
            chk(rx_ready == 1'b0, "R7", "ready cleared by read", rx_ready, 0);
        end

        // R1: code 2 reads as zero
        rdreg(2'b10, rv);
        chk(rv == 32'h0, "R1", "transmit register reads zero", rv, 0);

        // R5: second write during a frame is ignored
        dv = 16;
        configure(32'd64, 32'd4);
        wr(2'b10, 32'h0000_0096);
        wr(2'b10, 32'h0000_0069);
        capture(dv, fr);
        chk(fr == {1'b1, 8'h96, 1'b0}, "R5", "frame in flight unchanged", fr, {1'b1, 8'h96, 1'b0});
        quiet_check(20 * dv, "R5", "no second frame");

        // R8: two frames before a read, second one kept
        send(dv, 8'h12, 1'b1);
        send(dv, 8'hE7, 1'b1);
        chk(rx_ready == 1'b1, "R8", "ready still high", rx_ready, 1);
        rdreg(2'b11, rv);
        chk(rv == 32'h0000_00E7, "R8", "overwritten byte", rv, 32'hE7);

        // R9: low stop bit discards the frame
        send(dv, 8'h5C, 1'b0);
        repeat (2 * dv) @(negedge clk);
        chk(rx_ready == 1'b0, "R9", "no ready on bad stop", rx_ready, 0);
        rdreg(2'b11, rv);
        chk(rv == 32'h0000_00E7, "R9", "held byte kept", rv, 32'hE7);

        // R10: short low glitch rejected
        @(negedge clk);
        ser_rx = 1'b0;
        repeat (3) @(negedge clk);
        ser_rx = 1'b1;
        repeat (12 * dv) @(negedge clk);
        chk(rx_ready == 1'b0, "R10", "glitch gives no byte", rx_ready, 0);
        send(dv, 8'h81, 1'b1);
        rdreg(2'b11, rv);
        chk(rv == 32'h0000_0081, "R10", "good frame after glitch", rv, 32'h81);

        // R3: rate above clock gives invalid divisor; port stays silent
        configure(32'd64, 32'd100);
        wr(2'b10, 32'h0000_0000);
        quiet_check(300, "R3", "line quiet with quotient zero");
        send(16, 8'h44, 1'b1);
        chk(rx_ready == 1'b0, "R3", "receiver off with invalid divisor", rx_ready, 0);

        // R3: zero rate is also invalid
        configure(32'd64, 32'd0);
        wr(2'b10, 32'h0000_0000);
        quiet_check(300, "R3", "line quiet with zero rate");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule